// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one down-counting timer channel of the kind found in a classic PC interval timer. A host loads a 16-bit count together with an operating mode. The channel then counts ticks of its clock and shapes a single output according to the mode. Six modes are available: a terminal-count flag, a gate-triggered one-shot, a periodic rate generator, a square wave, a strobe started by software and a strobe started by the gate. The gate input acts in one of two ways, depending on the mode. In some modes its level pauses and resumes counting. In the others its rising edge restarts the count.

The channel is built around a five-state controller. S_IDLE is the state after reset. S_ARM is the one cycle in which a freshly written count waits to be transferred into the counting element. S_WAIT holds a gate-triggered mode until its first trigger. S_RUN is the counting state. S_DONE is a terminal state that holds the final output.

The transitions are as follows. A load moves any state to S_ARM. S_ARM moves to S_WAIT for modes 1 and 5, and to S_RUN for every other mode. S_WAIT moves to S_RUN on a gate rising edge. S_RUN moves to S_DONE when the count expires in modes 0, 1, 4 and 5. S_DONE moves back to S_RUN on a gate rising edge in modes 1 and 5. Modes 2 and 3 never leave S_RUN unless a new count is loaded.

Top module: `pit_channel`

## Requirements
- R1: After reset, out_o and null_cnt_o are 0, count_o reads 0, and the channel does not count until a count is loaded.
- R2: A clock edge with load_i high captures load_val_i, mode_i and bcd_i, and sets null_cnt_o. At the next edge the count is transferred, null_cnt_o clears and count_o shows the value. bcd_i is only reported on bcd_o, and counting is always binary.
- R3: A loaded value of 0 stands for 65536. count_o reads 0 after the transfer and 0xFFFF after one counted tick.
- R4: Mode 0 (mode_i=0): out_o is low from the load onwards. It goes high at the edge where the count reaches 0, N counted ticks after the transfer, and stays high until the next load.
- R5: In modes 0 and 4, gate_i high enables counting and gate_i low freezes the count. A gate rising edge does not reload the count.
- R6: Mode 1: out_o is high after the load and while waiting. A gate rising edge starts the count and drives out_o low. out_o goes high again N ticks later.
- R7: Mode 2: out_o is high for exactly one clock every N counted ticks, and not at the transfer. The count reloads N automatically.
- R8: Mode 3 (N of 2 or more): counting from the transfer, out_o is high for the first (N+1)/2 ticks of each N-tick period and low for the rest. count_o steps down by 2 each tick.
- R9: Mode 4: out_o stays low while counting, is high for one clock N ticks after the transfer, and the channel then stops at count 0 without reloading.
- R10: Mode 5: the count starts at a gate rising edge. out_o is a one-clock high strobe N ticks after that edge, and the channel does not reload.
- R11: In modes 1, 2, 3 and 5, a gate rising edge while counting or finished restarts counting from the loaded value.
- R12: mode_i values 6 and 7 behave as modes 2 and 3.
- R13: A load in any state aborts the current count, and the new count takes effect one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock; every edge is one tick |
| rst_n | input | 1 | Active-low synchronous reset |
| gate_i | input | 1 | Gate: level enable or rising-edge trigger, depending on mode |
| mode_i | input | 3 | Operating mode, binary 0 to 7, captured on load |
| bcd_i | input | 1 | Decimal-count flag, captured on load and reported only |
| load_i | input | 1 | Count-load strobe |
| load_val_i | input | CW | Count value to load, 0 meaning 2^CW |
| out_o | output | 1 | Channel output |
| count_o | output | CW | Live count value |
| null_cnt_o | output | 1 | High from the load edge until the count is transferred |
| bcd_o | output | 1 | Stored decimal-count flag |

## Verification
The bench builds the channel at its default width of 16 bits. At that width the zero-means-full-range rule shows in a single tick, as the wrap from 0 to 0xFFFF, without counting 65536 ticks. Small counts of 3 to 6 keep every period short, so the tests cover several whole periods of the rate and square-wave modes, odd and even square-wave halves, and both aliased mode codes, all within a few hundred cycles.

// File: rtl/pit_pkg.sv
package pit_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ARM,
        S_WAIT,
        S_RUN,
        S_DONE
    } chan_state_e;

    typedef enum logic [2:0] {
        M_TC_INT    = 3'd0,
        M_ONESHOT   = 3'd1,
        M_RATE      = 3'd2,
        M_SQUARE    = 3'd3,
        M_SW_STROBE = 3'd4,
        M_HW_STROBE = 3'd5
    } chan_mode_e;

    // codes 6 and 7 fold onto the periodic modes
    function automatic chan_mode_e fold_mode(input logic [2:0] m);
        if (m[2] && m[1]) begin
            return chan_mode_e'({1'b0, m[1:0]});
        end
        return chan_mode_e'(m);
    endfunction

endpackage

// File: rtl/pit_gate_edge.sv
module pit_gate_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= lvl_i;
        end
    end

    assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/pit_reload.sv
module pit_reload #(
    parameter int CW = 16
) (
    input  logic [CW-1:0] val_i,
    output logic [CW:0]   full_o,
    output logic [CW:0]   hi_o,
    output logic [CW:0]   lo_o
);
    localparam int XW = CW + 1;

    always_comb begin
        full_o = (val_i == '0) ? (XW'(1) << CW) : {1'b0, val_i};
        // odd counts give the extra tick to the high half
        hi_o   = full_o + XW'(full_o[0]);
        lo_o   = full_o - XW'(full_o[0]);
    end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gate_i,
    input  logic [2:0]    mode_i,
    input  logic          bcd_i,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          out_o,
    output logic [CW-1:0] count_o,
    output logic          null_cnt_o,
    output logic          bcd_o
);
    localparam int XW = CW + 1;
    localparam logic [XW-1:0] ONE = XW'(1);
    localparam logic [XW-1:0] TWO = XW'(2);

    chan_state_e   st, st_nx;
    chan_mode_e    mode_q;
    logic [CW-1:0] val_q;
    logic [XW-1:0] cnt;
    logic          out_q, null_q, bcd_q;

    logic          gate_rise;
    logic [XW-1:0] full_n, hi_n, lo_n;
    logic          trig_mode, retrig_mode, is_sq, ends_once;
    logic          cnt_en, restart;

    pit_gate_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (gate_i),
        .rise_o (gate_rise)
    );

    pit_reload #(.CW(CW)) u_rel (
        .val_i  (val_q),
        .full_o (full_n),
        .hi_o   (hi_n),
        .lo_o   (lo_n)
    );

    always_comb begin
        trig_mode   = (mode_q == M_ONESHOT) || (mode_q == M_HW_STROBE);
        is_sq       = (mode_q == M_SQUARE);
        retrig_mode = trig_mode || is_sq || (mode_q == M_RATE);
        ends_once   = !(is_sq || (mode_q == M_RATE));
        cnt_en      = trig_mode ? 1'b1 : gate_i;
        restart     = ((st == S_WAIT) && gate_rise)
                   || ((st == S_RUN)  && gate_rise && retrig_mode)
                   || ((st == S_DONE) && gate_rise && trig_mode);
    end

    // next-state logic
    always_comb begin
        st_nx = st;
        if (load_i) begin
            st_nx = S_ARM;
        end else begin
            unique case (st)
                S_IDLE: st_nx = S_IDLE;
                S_ARM:  st_nx = trig_mode ? S_WAIT : S_RUN;
                S_WAIT: st_nx = restart ? S_RUN : S_WAIT;
                S_RUN: begin
                    if (!restart && cnt_en && ends_once && (cnt == ONE)) begin
                        st_nx = S_DONE;
                    end
                end
                S_DONE: st_nx = restart ? S_RUN : S_DONE;
                default: st_nx = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // counting element and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= M_TC_INT;
            val_q  <= '0;
            cnt    <= '0;
            out_q  <= 1'b0;
            null_q <= 1'b0;
            bcd_q  <= 1'b0;
        end else if (load_i) begin
            mode_q <= fold_mode(mode_i);
            val_q  <= load_val_i;
            bcd_q  <= bcd_i;
            null_q <= 1'b1;
            out_q  <= (fold_mode(mode_i) == M_ONESHOT) || (fold_mode(mode_i) == M_SQUARE);
        end else begin
            unique case (st)
                S_IDLE: ;
                S_ARM: begin
                    null_q <= 1'b0;
                    cnt    <= is_sq ? hi_n : full_n;
                end
                S_WAIT: begin
                    if (restart) begin
                        cnt   <= full_n;
                        out_q <= 1'b0;
                    end
                end
                S_RUN: begin
                    if (restart) begin
                        cnt   <= is_sq ? hi_n : full_n;
                        out_q <= is_sq;
                    end else if (cnt_en) begin
                        unique case (mode_q)
                            M_RATE: begin
                                out_q <= (cnt == ONE);
                                cnt   <= (cnt == ONE) ? full_n : cnt - ONE;
                            end
                            M_SQUARE: begin
                                if (cnt == TWO) begin
                                    out_q <= ~out_q;
                                    cnt   <= out_q ? lo_n : hi_n;
                                end else begin
                                    cnt <= cnt - TWO;
                                end
                            end
                            default: begin
                                out_q <= (cnt == ONE);
                                cnt   <= cnt - ONE;
                            end
                        endcase
                    end else if (mode_q == M_RATE || mode_q == M_SW_STROBE) begin
                        out_q <= 1'b0;
                    end
                end
                S_DONE: begin
                    if (restart) begin
                        cnt   <= full_n;
                        out_q <= 1'b0;
                    end else if (mode_q == M_SW_STROBE || mode_q == M_HW_STROBE) begin
                        out_q <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    assign out_o      = out_q;
    assign count_o    = cnt[CW-1:0];
    assign null_cnt_o = null_q;
    assign bcd_o      = bcd_q;
endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk
    import pit_pkg::*;
#(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          load_i,
    input logic          gate_i,
    input logic          out_o,
    input logic          null_cnt_o,
    input logic [CW-1:0] count_o,
    input chan_mode_e    mode_q,
    input chan_state_e   st
);
    // R2: a load always raises the null-count flag
    p_load_sets_null_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> null_cnt_o);

    // R2: the flag lasts a single cycle without a further load
    p_null_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (null_cnt_o && !load_i) |=> !null_cnt_o);

    // R4: terminal output holds until reload
    p_tc_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_DONE && mode_q == M_TC_INT && !load_i) |=> out_o);

    // R5: gate low freezes the count in mode 0
    p_gate_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RUN && mode_q == M_TC_INT && !gate_i && !load_i) |=> $stable(count_o));

    // R6: one-shot output low while running
    p_oneshot_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RUN && mode_q == M_ONESHOT) |-> !out_o);

    // R9/R10: strobes last one clock
    p_strobe_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == M_SW_STROBE || mode_q == M_HW_STROBE) && out_o && !load_i) |=> !out_o);
endmodule

bind pit_channel pit_channel_chk #(.CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_i),
    .gate_i     (gate_i),
    .out_o      (out_o),
    .null_cnt_o (null_cnt_o),
    .count_o    (count_o),
    .mode_q     (mode_q),
    .st         (st)
);

// File: tb/pit_channel_tb.sv
module pit_channel_tb;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          gate_i = 1'b1;
    logic [2:0]    mode_i = '0;
    logic          bcd_i = 1'b0;
    logic          load_i = 1'b0;
    logic [CW-1:0] load_val_i = '0;
    logic          out_o, null_cnt_o, bcd_o;
    logic [CW-1:0] count_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pit_channel #(.CW(CW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .gate_i     (gate_i),
        .mode_i     (mode_i),
        .bcd_i      (bcd_i),
        .load_i     (load_i),
        .load_val_i (load_val_i),
        .out_o      (out_o),
        .count_o    (count_o),
        .null_cnt_o (null_cnt_o),
        .bcd_o      (bcd_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // returns just after the capture edge
    task automatic load(input int m, input int v, input bit b = 1'b0);
        mode_i     = 3'(m);
        load_val_i = CW'(v);
        bcd_i      = b;
        load_i     = 1'b1;
        tick();
        load_i     = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 out", out_o, 0);
        chk("R1 null", null_cnt_o, 0);
        chk("R1 count", count_o, 0);
        tick(3);
        chk("R1 idle count", count_o, 0);
    endtask

    task automatic t_mode0;
        gate_i = 1'b1;
        load(0, 5);
        chk("R2 null set", null_cnt_o, 1);
        chk("R4 out low on load", out_o, 0);
        tick();
        chk("R2 null clear", null_cnt_o, 0);
        chk("R2 transfer", count_o, 5);
        tick(4);
        chk("R4 count 1", count_o, 1);
        chk("R4 out still low", out_o, 0);
        tick();
        chk("R4 out high", out_o, 1);
        chk("R4 count 0", count_o, 0);
        tick(3);
        chk("R4 out holds", out_o, 1);
    endtask

    task automatic t_gate_level;
        gate_i = 1'b1;
        load(0, 6);
        tick(3);
        chk("R5 counting", count_o, 4);
        gate_i = 1'b0;
        tick(2);
        chk("R5 frozen", count_o, 4);
        gate_i = 1'b1;
        tick();
        chk("R5 no reload on rise", count_o, 3);
        load(4, 3);
        tick();
        gate_i = 1'b0;
        tick();
        chk("R5 mode4 frozen", count_o, 3);
        gate_i = 1'b1;
        tick(2);
        chk("R9 strobe not yet", out_o, 0);
        tick();
        chk("R9 strobe", out_o, 1);
        chk("R9 count 0", count_o, 0);
        tick();
        chk("R9 strobe ends", out_o, 0);
        tick(2);
        chk("R9 no reload", count_o, 0);
    endtask

    task automatic t_zero_bcd;
        gate_i = 1'b1;
        load(0, 0);
        tick();
        chk("R3 full range", count_o, 0);
        chk("R3 out low", out_o, 0);
        tick();
        chk("R3 wrap", count_o, 16'hFFFF);
        load(0, 16'h10, 1'b1);
        chk("R2 bcd stored", bcd_o, 1);
        tick(2);
        chk("R2 binary count", count_o, 16'h0F);
    endtask

    task automatic t_rate(input int m, input int n, input string req);
        gate_i = 1'b1;
        load(m, n);
        tick();
        for (int k = 0; k <= 3 * n; k++) begin
            chk(req, out_o, (k > 0 && k % n == 0) ? 1 : 0);
            chk(req, count_o, n - (k % n));
            tick();
        end
    endtask

    task automatic t_square(input int m, input int n, input string req);
        gate_i = 1'b1;
        load(m, n);
        tick();
        for (int k = 0; k < 3 * n; k++) begin
            chk(req, out_o, ((k % n) < (n + 1) / 2) ? 1 : 0);
            if (k == 0) chk("R8 start count", count_o, n + (n % 2));
            if (k == 1) chk("R8 step by two", count_o, n + (n % 2) - 2);
            tick();
        end
    endtask

    task automatic t_oneshot;
        gate_i = 1'b0;
        tick(2);
        load(1, 4);
        chk("R6 high after load", out_o, 1);
        tick(2);
        chk("R6 waiting", out_o, 1);
        chk("R6 waiting count", count_o, 4);
        gate_i = 1'b1;
        tick();
        chk("R6 low on trigger", out_o, 0);
        tick(2);
        chk("R6 count", count_o, 2);
        gate_i = 1'b0;
        tick();
        chk("R6 gate level ignored", count_o, 1);
        gate_i = 1'b1;
        tick();
        chk("R11 retrigger count", count_o, 4);
        tick(3);
        chk("R11 still low", out_o, 0);
        tick();
        chk("R6 high at end", out_o, 1);
    endtask

    task automatic t_hw_strobe;
        gate_i = 1'b0;
        tick(2);
        load(5, 3);
        tick(3);
        chk("R10 waits for gate", count_o, 3);
        chk("R10 out low", out_o, 0);
        gate_i = 1'b1;
        tick(3);
        chk("R10 not yet", out_o, 0);
        tick();
        chk("R10 strobe", out_o, 1);
        tick();
        chk("R10 strobe ends", out_o, 0);
        chk("R10 no reload", count_o, 0);
        gate_i = 1'b0;
        tick();
        gate_i = 1'b1;
        tick();
        chk("R11 mode5 retrigger", count_o, 3);
    endtask

    task automatic t_rate_retrig;
        gate_i = 1'b1;
        load(2, 5);
        tick(3);
        chk("R7 count", count_o, 3);
        gate_i = 1'b0;
        tick();
        chk("R7 gate low freezes", count_o, 3);
        gate_i = 1'b1;
        tick();
        chk("R11 mode2 retrigger", count_o, 5);
    endtask

    task automatic t_reload;
        gate_i = 1'b1;
        load(0, 9);
        tick(3);
        load(0, 20);
        chk("R13 null on reload", null_cnt_o, 1);
        tick();
        chk("R13 new count", count_o, 20);
        chk("R13 out low", out_o, 0);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_mode0();
        t_gate_level();
        t_zero_bcd();
        t_rate(2, 4, "R7 rate");
        t_rate(6, 3, "R12 alias 6");
        t_square(3, 5, "R8 odd square");
        t_square(3, 4, "R8 even square");
        t_square(7, 4, "R12 alias 7");
        t_oneshot();
        t_hw_strobe();
        t_rate_retrig();
        t_reload();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule